// File: doc/BRIEF.md
# Edge-Triggered Interrupt Aggregator

This block merges three groups of interrupt sources into one interrupt line toward a processor. The groups are a display group, a graphics-engine group and a power-management group. Each group has a 32-bit status register and a 32-bit enable register. Event inputs latch into the status bits. Software acknowledges a bit by writing a one to it. A global gate bit controls only the graphics and power groups. The display group always reaches the output, whatever the gate bit holds.

The output is edge-based, not level-based. The block forms one combined "something enabled is pending" condition and emits a single-cycle pulse only when that condition goes from low to high. A handler can therefore disarm the line by dropping the gate bit and the display enable before it acknowledges. When it restores them with sources still pending, the condition rises again and a fresh pulse is produced, so no interrupt is lost.

Top module: `irq_edge_combiner`

## Requirements
- R1: After reset every register reads zero and `cpu_irq` is low.
- R2: A one on a bit of `disp_evt`, `gfx_evt` or `pwr_evt` sets the matching status bit. This happens whatever the enable registers and the gate bit hold.
- R3: Status registers clear on write-1. Byte offsets are: display status 0x04, graphics status 0x0C, power status 0x14. Writing a one clears that bit. Writing a zero leaves it unchanged.
- R4: If an event and a write-1 acknowledge hit the same status bit in the same cycle, the bit ends up set.
- R5: The enable registers are read/write at display 0x08, graphics 0x10 and power 0x18. The gate register at 0x00 stores only bit 31. Its other bits read as zero.
- R6: The combined condition is this: (display status AND display enable) nonzero, OR the gate bit set together with either (graphics status AND graphics enable) nonzero or (power status AND power enable) nonzero. When the condition rises, `cpu_irq` is high for exactly one cycle. That cycle is the one after the first cycle in which the condition is true.
- R7: The gate bit has no effect on the display term.
- R8: While the combined condition stays high, new events produce no further pulse.
- R9: Clearing the gate bit and the display enable, then restoring them while enabled bits are still pending, produces a new pulse.
- R10: If the gate bit is restored first and only display bits are pending, no pulse occurs until the display enable is written. The pulse then follows that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| disp_evt | input | 32 | Display-group event bits |
| gfx_evt | input | 32 | Graphics-group event bits |
| pwr_evt | input | 32 | Power-group event bits |
| cpu_irq | output | 1 | Single-cycle interrupt pulse |

## Verification
Two things can land on the same status bit in one clock: an incoming event and a write-1 acknowledge. The bench raises `disp_evt` bit 0 in the same cycle it writes ones to status bits 0 and 1. Bit 1 was already pending and bit 0 was not. A correct result is status 0x1: the event wins on bit 0 and the acknowledge takes effect on bit 1. A second overlap involves the edge detector. A new event can arrive while the combined condition is already high. That case is judged by confirming the output stays silent for several cycles.

// File: rtl/irq_edge_combiner.sv
module irq_edge_combiner #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int GATE_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] disp_evt,
  input  logic [DW-1:0] gfx_evt,
  input  logic [DW-1:0] pwr_evt,
  output logic          cpu_irq
);
  localparam logic [AW-1:0] OFS_GATE = AW'(8'h00);
  localparam logic [AW-1:0] OFS_DST  = AW'(8'h04);
  localparam logic [AW-1:0] OFS_DEN  = AW'(8'h08);
  localparam logic [AW-1:0] OFS_GST  = AW'(8'h0C);
  localparam logic [AW-1:0] OFS_GEN  = AW'(8'h10);
  localparam logic [AW-1:0] OFS_PST  = AW'(8'h14);
  localparam logic [AW-1:0] OFS_PEN  = AW'(8'h18);

  logic          gate_q;
  logic [DW-1:0] disp_stat, disp_en, gfx_stat, gfx_en, pwr_stat, pwr_en;
  logic          cond, cond_q;

  function automatic logic [DW-1:0] ack(input logic hit, input logic [DW-1:0] d);
    return hit ? d : '0;
  endfunction

  wire [DW-1:0] disp_ack = ack(bus_wr && bus_addr == OFS_DST, bus_wdata);
  wire [DW-1:0] gfx_ack  = ack(bus_wr && bus_addr == OFS_GST, bus_wdata);
  wire [DW-1:0] pwr_ack  = ack(bus_wr && bus_addr == OFS_PST, bus_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q    <= 1'b0;
      disp_stat <= '0;
      disp_en   <= '0;
      gfx_stat  <= '0;
      gfx_en    <= '0;
      pwr_stat  <= '0;
      pwr_en    <= '0;
    end else begin
      disp_stat <= (disp_stat & ~disp_ack) | disp_evt;
      gfx_stat  <= (gfx_stat  & ~gfx_ack)  | gfx_evt;
      pwr_stat  <= (pwr_stat  & ~pwr_ack)  | pwr_evt;
      if (bus_wr) begin
        case (bus_addr)
          OFS_GATE: gate_q  <= bus_wdata[GATE_BIT];
          OFS_DEN:  disp_en <= bus_wdata;
          OFS_GEN:  gfx_en  <= bus_wdata;
          OFS_PEN:  pwr_en  <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  wire disp_act = |(disp_stat & disp_en);
  wire gfx_act  = |(gfx_stat & gfx_en);
  wire pwr_act  = |(pwr_stat & pwr_en);
  assign cond = disp_act | (gate_q & (gfx_act | pwr_act));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q  <= 1'b0;
      cpu_irq <= 1'b0;
    end else begin
      cond_q  <= cond;
      cpu_irq <= cond & ~cond_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_GATE: bus_rdata[GATE_BIT] = gate_q;
      OFS_DST:  bus_rdata = disp_stat;
      OFS_DEN:  bus_rdata = disp_en;
      OFS_GST:  bus_rdata = gfx_stat;
      OFS_GEN:  bus_rdata = gfx_en;
      OFS_PST:  bus_rdata = pwr_stat;
      OFS_PEN:  bus_rdata = pwr_en;
      default:  bus_rdata = '0;
    endcase
  end

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((disp_stat & $past(disp_evt)) == $past(disp_evt)) &&
             ((gfx_stat & $past(gfx_evt)) == $past(gfx_evt)) &&
             ((pwr_stat & $past(pwr_evt)) == $past(pwr_evt)));

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DST && disp_evt == '0) |=>
      disp_stat == ($past(disp_stat) & ~$past(bus_wdata)));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_GST) |=>
      (gfx_stat & $past(gfx_evt)) == $past(gfx_evt));

  p_gate_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_GATE) |-> bus_rdata[GATE_BIT-1:0] == '0);

  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |=> !cpu_irq);

  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> $past(|(disp_stat & disp_en) || gate_q));
endmodule

// File: tb/irq_edge_combiner_tb.sv
module irq_edge_combiner_tb_top;
  localparam int AW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] disp_evt = '0, gfx_evt = '0, pwr_evt = '0;
  logic cpu_irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_edge_combiner #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .disp_evt(disp_evt),
    .gfx_evt(gfx_evt), .pwr_evt(pwr_evt), .cpu_irq(cpu_irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic evt(input logic [31:0] d, input logic [31:0] g, input logic [31:0] p);
    @(negedge clk);
    disp_evt = d; gfx_evt = g; pwr_evt = p;
    @(negedge clk);
    disp_evt = '0; gfx_evt = '0; pwr_evt = '0;
  endtask

  // called at the negedge after the triggering edge: low now, high next, low after
  task automatic expect_pulse(input string tag);
    chk({tag, " pre"}, {31'b0, cpu_irq}, 32'd0);
    @(negedge clk);
    chk({tag, " pulse"}, {31'b0, cpu_irq}, 32'd1);
    @(negedge clk);
    chk({tag, " post"}, {31'b0, cpu_irq}, 32'd0);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      if (cpu_irq) seen++;
      @(negedge clk);
    end
    chk({tag, " quiet"}, seen, 0);
  endtask

  task automatic t_reset;
    for (int a = 0; a <= 'h18; a += 4) rd(8'(a), 32'd0, "R1 reg after reset");
    chk("R1 irq after reset", {31'b0, cpu_irq}, 32'd0);
  endtask

  task automatic t_sticky;
    evt(32'h5, 32'h10, 32'h300);
    rd(8'h04, 32'h5, "R2 display status");
    rd(8'h0C, 32'h10, "R2 graphics status");
    rd(8'h14, 32'h300, "R2 power status");
    expect_quiet(4, "R2 no enables");
  endtask

  task automatic t_w1c;
    wr(8'h04, 32'h1);  rd(8'h04, 32'h4, "R3 clear one bit");
    wr(8'h04, 32'h0);  rd(8'h04, 32'h4, "R3 zero write keeps");
    wr(8'h04, 32'h4);  rd(8'h04, 32'h0, "R3 clear last bit");
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, 32'h0, "R3 graphics clear");
    wr(8'h14, 32'h100); rd(8'h14, 32'h200, "R3 power partial");
    wr(8'h14, 32'h200); rd(8'h14, 32'h0, "R3 power clear");
  endtask

  task automatic t_setwins;
    evt(32'h2, 32'h0, 32'h0);
    @(negedge clk);
    disp_evt = 32'h1; bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h3;
    @(negedge clk);
    disp_evt = '0; bus_wr = 1'b0; bus_wdata = '0;
    rd(8'h04, 32'h1, "R4 set beats ack");
    wr(8'h04, 32'h1); rd(8'h04, 32'h0, "R4 cleanup");
  endtask

  task automatic t_regs;
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, 32'h8000_0000, "R5 gate reads bit31");
    wr(8'h00, 32'h7FFF_FFFF); rd(8'h00, 32'h0, "R5 gate cleared");
    wr(8'h08, 32'hA5A5_0001); rd(8'h08, 32'hA5A5_0001, "R5 display enable");
    wr(8'h10, 32'h0F0F_F0F0); rd(8'h10, 32'h0F0F_F0F0, "R5 graphics enable");
    wr(8'h18, 32'h1234_5678); rd(8'h18, 32'h1234_5678, "R5 power enable");
    wr(8'h08, 0); wr(8'h10, 0); wr(8'h18, 0);
    expect_quiet(2, "R5 no pending");
  endtask

  task automatic t_display;
    wr(8'h08, 32'h2);
    evt(32'h2, 32'h0, 32'h0);
    expect_pulse("R7 display with gate off");
    evt(32'h2, 32'h0, 32'h0);
    expect_quiet(4, "R8 held high");
    wr(8'h04, 32'h2);
    expect_quiet(2, "R6 cleared");
    wr(8'h08, 32'h0);
  endtask

  task automatic t_gated;
    wr(8'h10, 32'h1);
    evt(32'h0, 32'h1, 32'h0);
    expect_quiet(4, "R6 graphics gated");
    wr(8'h00, 32'h8000_0000);
    expect_pulse("R6 gate opens graphics");
    wr(8'h0C, 32'h1);
    wr(8'h18, 32'h4);
    evt(32'h0, 32'h0, 32'h4);
    expect_pulse("R6 power path");
  endtask

  task automatic t_rearm;
    wr(8'h00, 32'h0);
    expect_quiet(2, "R9 disarm");
    wr(8'h00, 32'h8000_0000);
    expect_pulse("R9 rearm power");
    wr(8'h14, 32'h4);
    wr(8'h08, 32'h10);
    evt(32'h10, 32'h0, 32'h0);
    expect_pulse("R9 display first");
    wr(8'h00, 32'h0);
    wr(8'h08, 32'h0);
    expect_quiet(2, "R9 both off");
    wr(8'h08, 32'h10);
    expect_pulse("R9 restore display");
  endtask

  task automatic t_order;
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h0);
    wr(8'h00, 32'h8000_0000);
    expect_quiet(4, "R10 gate first no pulse");
    wr(8'h08, 32'h10);
    expect_pulse("R10 display enable write");
    wr(8'h04, 32'h10);
  endtask

  initial begin
    #55000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_sticky;
    t_w1c;
    t_setwins;
    t_regs;
    t_display;
    t_gated;
    t_rearm;
    t_order;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule